// File: doc/BRIEF.md
# Boot Memory Remap Controller

This block chooses which memory responds in the address window at the bottom of the application processor's map. The processor always takes its first fetch from address zero. A small bank of configuration bits models non-volatile option storage. Bit 1 of that bank picks the boot target: clear means the boot ROM and set means on-chip Flash. The bits are changed only through a command port that takes set, clear and erase operations. Each command keeps a busy flag high for a fixed time and then gives a one-cycle done pulse. An erase brings the bank back to all zeros, so after an erase the part boots from ROM again.

The bank is cleared only by the power-on reset `por_ni`. The ordinary system reset `rst_ni` leaves it as it is. On the first clock edge after `rst_ni` is released, the block copies bit 1 into a boot selection register. That selection then stays fixed until the next system reset, so a command given at run time cannot move the alias under code that is already executing.

For every incoming address, the router returns a target code and the offset inside that target. The address space is split into regions by the upper address bits. Region 0 is the alias window and is sent to ROM or Flash according to the latched selection. Every other region goes to its own native target.

Top module: `boot_remap_ctrl`

## Requirements
- R1: After a power-on reset, `cfg_o` is all zeros, `boot_sel_o` is 0 (ROM), and `busy_o`, `done_o`, `err_o` and `coll_o` are all 0.
- R2: A completed command with `cmd_op_i`=2'b01 sets bit `cmd_idx_i` of `cfg_o`. A completed command with `cmd_op_i`=2'b10 clears that bit. No other bit changes.
- R3: A completed command with `cmd_op_i`=2'b11 (erase) clears every configuration bit, including bit 1, whatever the index. Erase never raises `err_o`.
- R4: A command is accepted on a rising edge when `cmd_valid_i` is high and `busy_o` is low. From that edge `busy_o` stays high for exactly BUSY_CYCLES cycles. It then falls in the same cycle that `done_o` pulses high for one cycle and `cfg_o` shows the result. Opcode 2'b00 is a no-op that runs the same timing.
- R5: A set or clear command whose index is NUM_BITS or larger leaves `cfg_o` unchanged and drives `err_o` high from its done cycle. The next command to complete with a valid index, or an erase, returns `err_o` to 0.
- R6: A `cmd_valid_i` seen while `busy_o` is high is ignored and sets `coll_o`. The next accepted command clears `coll_o`.
- R7: `boot_sel_o` takes the value of configuration bit 1 on the first rising edge after `rst_ni` is released. It is 0 while `rst_ni` is low and holds its value until the next system reset. `rst_ni` alone does not change `cfg_o`.
- R8: An address whose region (bits ADDR_W-1 down to REG_AW) is 0 gives `tgt_o`=2'b01 (Flash) when `boot_sel_o` is 1 and `tgt_o`=2'b00 (ROM) when it is 0.
- R9: Outside region 0, region ROM_REG gives `tgt_o`=2'b00, region FLASH_REG gives 2'b01, and any other region gives 2'b10, whatever `boot_sel_o` is. In every region `off_o` equals the low REG_AW address bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Active-low power-on reset; clears the configuration bank |
| rst_ni | input | 1 | Active-low system reset; re-arms boot selection sampling |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 2 | 00 no-op, 01 set bit, 10 clear bit, 11 erase |
| cmd_idx_i | input | IDX_W | Bit index for set and clear |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last completed set or clear had an out-of-range index |
| coll_o | output | 1 | A request arrived while busy and was dropped |
| cfg_o | output | NUM_BITS | Current configuration bits |
| boot_sel_o | output | 1 | Latched boot target: 0 ROM, 1 Flash |
| addr_i | input | ADDR_W | Incoming bus address |
| tgt_o | output | 2 | Routed target: 00 ROM, 01 Flash, 10 other |
| off_o | output | REG_AW | Offset within the routed target |

## Verification
Every index from 0 up to twice the bank size is set and then cleared. This separates valid indices, which change one bit, from out-of-range ones, which only raise the error flag. A back-to-back request during busy shows whether a dropped command leaks into the bank. Set, clear and erase are then mixed with system resets. This tells whether the boot selection follows the stored bit at reset release and stays put when the bit changes afterwards. The full address space is swept with both boot selections, which separates alias-window routing from pass-through routing of the native regions.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_SET   = 2'b01,
    OP_CLR   = 2'b10,
    OP_ERASE = 2'b11
  } cmd_op_e;

  typedef enum logic [1:0] {
    TGT_ROM   = 2'b00,
    TGT_FLASH = 2'b01,
    TGT_OTHER = 2'b10
  } tgt_e;

  localparam int BOOT_BIT = 1;
endpackage

// File: rtl/remap_cmd_seq.sv
module remap_cmd_seq
  import boot_remap_pkg::*;
#(
  parameter int NUM_BITS    = 4,
  parameter int IDX_W       = 3,
  parameter int BUSY_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  cmd_op_e          cmd_op_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             coll_o,
  output logic             apply_o,
  output cmd_op_e          op_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(BUSY_CYCLES - 1);

  logic             busy_q, done_q, err_q, coll_q;
  logic [CNT_W-1:0] cnt_q;
  cmd_op_e          op_q;
  logic [IDX_W-1:0] idx_q;
  logic             accept, last, bad_idx;

  assign accept  = cmd_valid_i && !busy_q;
  assign last    = busy_q && (cnt_q == '0);
  assign bad_idx = ((op_q == OP_SET) || (op_q == OP_CLR)) && (int'(idx_q) >= NUM_BITS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      coll_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_NOP;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_INIT;
        op_q   <= cmd_op_i;
        idx_q  <= cmd_idx_i;
        coll_q <= 1'b0;
      end else begin
        if (cmd_valid_i) coll_q <= 1'b1;  // dropped while busy
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          err_q  <= bad_idx;
        end else if (busy_q) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign coll_o  = coll_q;
  assign apply_o = last;
  assign op_o    = op_q;
  assign idx_o   = idx_q;

  assert_done_after_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(busy_q) && !busy_q));
  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_busy_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cmd_valid_i) |=> (coll_q && $stable(op_q) && $stable(idx_q)));
endmodule

// File: rtl/remap_cfg_store.sv
module remap_cfg_store
  import boot_remap_pkg::*;
#(
  parameter int NUM_BITS = 4,
  parameter int IDX_W    = 3
) (
  input  logic                clk_i,
  input  logic                por_ni,
  input  logic                apply_i,
  input  cmd_op_e             op_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [NUM_BITS-1:0] cfg_o
);
  logic [NUM_BITS-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      cfg_q <= '0;
    end else if (apply_i) begin
      for (int i = 0; i < NUM_BITS; i++) begin
        if (op_i == OP_ERASE) begin
          cfg_q[i] <= 1'b0;
        end else if (idx_i == IDX_W'(i)) begin
          if (op_i == OP_SET)      cfg_q[i] <= 1'b1;
          else if (op_i == OP_CLR) cfg_q[i] <= 1'b0;
        end
      end
    end
  end

  assign cfg_o = cfg_q;

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!por_ni)
    !apply_i |=> $stable(cfg_q));
  assert_bad_idx_R5: assert property (@(posedge clk_i) disable iff (!por_ni)
    (apply_i && (op_i == OP_SET || op_i == OP_CLR) && int'(idx_i) >= NUM_BITS) |=> $stable(cfg_q));
  assert_erase_boot_R3: assert property (@(posedge clk_i) disable iff (!por_ni)
    (apply_i && op_i == OP_ERASE) |=> (cfg_q[BOOT_BIT] == 1'b0));
endmodule

// File: rtl/remap_addr_route.sv
module remap_addr_route
  import boot_remap_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REG_AW    = 24,
  parameter int ROM_REG   = 1,
  parameter int FLASH_REG = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              boot_sel_i,
  output logic              alias_o,
  output tgt_e              tgt_o,
  output logic [REG_AW-1:0] off_o
);
  localparam int RG_W = ADDR_W - REG_AW;

  logic [RG_W-1:0] region;

  assign region  = addr_i[ADDR_W-1:REG_AW];
  assign alias_o = (region == '0);
  assign off_o   = addr_i[REG_AW-1:0];

  always_comb begin
    if (alias_o)                        tgt_o = boot_sel_i ? TGT_FLASH : TGT_ROM;
    else if (region == RG_W'(ROM_REG))   tgt_o = TGT_ROM;
    else if (region == RG_W'(FLASH_REG)) tgt_o = TGT_FLASH;
    else                                tgt_o = TGT_OTHER;
  end
endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl
  import boot_remap_pkg::*;
#(
  parameter int NUM_BITS    = 4,
  parameter int IDX_W       = $clog2(NUM_BITS) + 1,
  parameter int BUSY_CYCLES = 4,
  parameter int ADDR_W      = 32,
  parameter int REG_AW      = 24,
  parameter int ROM_REG     = 1,
  parameter int FLASH_REG   = 2
) (
  input  logic                clk_i,
  input  logic                por_ni,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_op_i,
  input  logic [IDX_W-1:0]    cmd_idx_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic                coll_o,
  output logic [NUM_BITS-1:0] cfg_o,
  output logic                boot_sel_o,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [1:0]          tgt_o,
  output logic [REG_AW-1:0]   off_o
);
  logic             apply;
  cmd_op_e          op;
  logic [IDX_W-1:0] idx;
  logic             armed_q, boot_sel_q, alias_hit;
  tgt_e             tgt;

  remap_cmd_seq #(
    .NUM_BITS(NUM_BITS), .IDX_W(IDX_W), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_e'(cmd_op_i)),
    .cmd_idx_i   (cmd_idx_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .coll_o      (coll_o),
    .apply_o     (apply),
    .op_o        (op),
    .idx_o       (idx)
  );

  remap_cfg_store #(
    .NUM_BITS(NUM_BITS), .IDX_W(IDX_W)
  ) u_store (
    .clk_i   (clk_i),
    .por_ni  (por_ni),
    .apply_i (apply),
    .op_i    (op),
    .idx_i   (idx),
    .cfg_o   (cfg_o)
  );

  // sample boot bit once per system reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b1;
      boot_sel_q <= 1'b0;
    end else if (armed_q) begin
      armed_q    <= 1'b0;
      boot_sel_q <= cfg_o[BOOT_BIT];
    end
  end

  assign boot_sel_o = boot_sel_q;

  remap_addr_route #(
    .ADDR_W(ADDR_W), .REG_AW(REG_AW), .ROM_REG(ROM_REG), .FLASH_REG(FLASH_REG)
  ) u_route (
    .addr_i     (addr_i),
    .boot_sel_i (boot_sel_q),
    .alias_o    (alias_hit),
    .tgt_o      (tgt),
    .off_o      (off_o)
  );

  assign tgt_o = tgt;

  assert_sel_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> $stable(boot_sel_q));
  assert_alias_flash_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alias_hit && boot_sel_q) |-> (tgt == TGT_FLASH));
  assert_alias_rom_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alias_hit && !boot_sel_q) |-> (tgt == TGT_ROM));
endmodule

// File: tb/boot_remap_ctrl_test.sv
module boot_remap_ctrl_test;
  localparam int NB = 4, IW = 3, BC = 3, AW = 12, RA = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          por_n, rst_n, cmd_valid;
  logic [1:0]    cmd_op;
  logic [IW-1:0] cmd_idx;
  logic [AW-1:0] addr;
  logic          busy, done, err, coll, boot_sel;
  logic [NB-1:0] cfg;
  logic [1:0]    tgt;
  logic [RA-1:0] off;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [NB-1:0] exp_cfg = '0;

  boot_remap_ctrl #(
    .NUM_BITS(NB), .IDX_W(IW), .BUSY_CYCLES(BC), .ADDR_W(AW), .REG_AW(RA),
    .ROM_REG(1), .FLASH_REG(2)
  ) uut (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_idx_i(cmd_idx),
    .busy_o(busy), .done_o(done), .err_o(err), .coll_o(coll),
    .cfg_o(cfg), .boot_sel_o(boot_sel),
    .addr_i(addr), .tgt_o(tgt), .off_o(off)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input int idx);
    bit exp_err;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = IW'(idx);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(coll == 1'b0, "R6 coll cleared on accept", coll, 0);
    for (int k = 0; k < BC; k++) begin
      chk(busy == 1'b1 && done == 1'b0, "R4 busy window", {busy, done}, 2);
      @(negedge clk);
    end
    if (op == 2'b01 && idx < NB) exp_cfg[idx] = 1'b1;  // R2
    if (op == 2'b10 && idx < NB) exp_cfg[idx] = 1'b0;  // R2
    if (op == 2'b11) exp_cfg = '0;                      // R3
    exp_err = (op == 2'b01 || op == 2'b10) && idx >= NB;
    chk(busy == 1'b0 && done == 1'b1, "R4 done pulse", {busy, done}, 1);
    chk(cfg == exp_cfg, "R2/R3 cfg after command", cfg, exp_cfg);
    chk(err == exp_err, "R5 error flag", err, exp_err);
    @(negedge clk);
    chk(done == 1'b0, "R4 done one cycle", done, 0);
  endtask

  task automatic sweep(input bit sel);
    for (int a = 0; a < (1 << AW); a++) begin
      int rg, et;
      addr = AW'(a);
      #1;
      rg = a >> RA;
      if (rg == 0)      et = sel ? 1 : 0;
      else if (rg == 1) et = 0;
      else if (rg == 2) et = 1;
      else              et = 2;
      if (rg == 0) chk(tgt == et && off == (a & 255), "R8 alias target", tgt, et);
      else         chk(tgt == et && off == (a & 255), "R9 native target", tgt, et);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_idx = '0; addr = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    chk(cfg == 0 && boot_sel == 0, "R1 reset cfg/boot", {cfg, boot_sel}, 0);
    chk({busy, done, err, coll} == 0, "R1 reset flags", {busy, done, err, coll}, 0);

    // R2/R5: every index set then cleared
    for (int i = 0; i < 2 * NB; i++) run_cmd(2'b01, i);
    for (int i = 0; i < 2 * NB; i++) run_cmd(2'b10, i);
    run_cmd(2'b01, 7);  // R5 bad index, err high
    run_cmd(2'b00, 0);  // R4 no-op timing, clears err
    run_cmd(2'b01, 5);
    run_cmd(2'b11, 6);  // R3 erase with bad index: no err

    // R6: request during busy is dropped
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_idx = 3'd0;
    @(negedge clk);
    cmd_op = 2'b11;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(coll == 1'b1, "R6 coll set", coll, 1);
    for (int k = 0; k < 4 * BC && !done; k++) @(negedge clk);
    exp_cfg[0] = 1'b1;
    chk(cfg == exp_cfg, "R6 dropped erase has no effect", cfg, exp_cfg);
    chk(coll == 1'b1, "R6 coll stays until next accept", coll, 1);
    run_cmd(2'b10, 0);

    // R7: selection follows bit 1 only at reset release
    sweep(1'b0);
    run_cmd(2'b01, 1);
    chk(boot_sel == 1'b0, "R7 no change at run time", boot_sel, 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(boot_sel == 1'b0, "R7 zero in reset", boot_sel, 0);
    chk(cfg == exp_cfg, "R7 cfg kept over system reset", cfg, exp_cfg);
    rst_n = 1'b1;
    @(negedge clk);
    chk(boot_sel == 1'b1, "R7 latched flash", boot_sel, 1);
    sweep(1'b1);
    run_cmd(2'b10, 1);
    chk(boot_sel == 1'b1, "R7 held after clear", boot_sel, 1);
    run_cmd(2'b01, 1);
    run_cmd(2'b01, 3);
    run_cmd(2'b11, 0);  // R3 erase returns boot bit to ROM
    chk(boot_sel == 1'b1, "R7 held after erase", boot_sel, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(boot_sel == 1'b0, "R3 erase boots ROM", boot_sel, 0);
    sweep(1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule